// File: doc/BRIEF.md
# Serial Fraction-to-Binary Converter

The block turns a decimal fraction into its binary expansion, one bit per clock. The fraction arrives as a numerator `numer` over a fixed denominator of ten to the power `DIGITS` (10000 with the default of four digits). Each step doubles the running remainder. When the doubled value reaches the denominator, a 1 is emitted and the denominator is subtracted. Otherwise a 0 is emitted. Bits leave on `bit_out` with a `bit_valid` strobe, most significant first. They are also gathered, left-justified, in the parallel `result` register.

A run stops in one of two ways. It stops when the remainder reaches zero, which means the expansion is exact. It also stops when the requested precision `prec` has been produced. A one-cycle `done` pulse then marks the end, with `nbits` giving the bit count and `exact` telling which way the run ended.

The controller has three states:

- `ST_IDLE` waits for an accepted start. It leaves on "load", going to `ST_RUN`, or to `ST_WRAP` when the numerator is zero.
- `ST_RUN` emits one bit per cycle. It leaves on "last step", which fires on a zero remainder or at the bit limit, and goes to `ST_WRAP`.
- `ST_WRAP` raises `done` and returns to `ST_IDLE` unconditionally.

Top module: `frac2bin_serial`

## Requirements
- R1: After reset, busy, bit_valid, bit_out, done and exact are 0, and result and nbits are 0.
- R2: A start is accepted only in the idle state and only when numer is below the denominator (10000 by default). A start with numer of 10000 or more is ignored: busy stays low, no bit is emitted, no done pulse occurs, and result keeps its value.
- R3: Each step doubles the remainder. If the doubled value is at least the denominator, the bit is 1 and the denominator is subtracted; otherwise the bit is 0. When the start is sampled on clock edge k, bit i (i from 0, MSB first) is shown with bit_valid high after edge k+1+i.
- R4: The run ends right after the step whose new remainder is zero. For example, numer 5625 yields the bits 1,0,0,1 and ends with exact=1 and nbits=4.
- R5: The bit limit is prec, clamped so that prec 0 gives 1 bit and any prec above 24 gives 24 bits. The run ends after the limit is reached even if the remainder is nonzero.
- R6: A numerator of zero emits no bits and ends with done, exact=1, nbits=0 and result=0.
- R7: done is high for exactly one cycle, after edge k+n+1 for n emitted bits. In that cycle busy and bit_valid are low.
- R8: result holds bit i at position 23-i, with zeros below the last produced bit. It is cleared when a start is accepted.
- R9: At done, nbits equals the number of bits emitted and exact is 1 exactly when the final remainder is zero. Both hold until the next accepted start.
- R10: A start asserted while busy is ignored. The running conversion continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion |
| numer | input | 14 | Numerator over 10^DIGITS |
| prec | input | 5 | Requested bit count |
| busy | output | 1 | Conversion in progress |
| bit_valid | output | 1 | bit_out carries a result bit |
| bit_out | output | 1 | Serial result bit, MSB first |
| done | output | 1 | One-cycle end pulse |
| exact | output | 1 | Run ended on a zero remainder |
| result | output | 24 | Left-justified collected bits |
| nbits | output | 5 | Number of bits produced |

## Verification
Every result has a fixed arrival time, counted from the edge that samples start:

- bit i is due one edge plus i further edges later;
- `done`, `result`, `nbits` and `exact` are due one edge after the last bit, so edge k+1 for a zero numerator;
- the cycle after that must show `done` low again.

The bench drives its inputs on falling edges and samples only on falling edges, each sample taken at exactly the cycle its count gives. A start that is rejected or that arrives while busy is checked one and two cycles later, through busy, bit_valid, done and the unchanged result.

// File: rtl/frac2bin_pkg.sv
package frac2bin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } f2b_state_e;

    // Requested bit count forced into the range 1..top.
    function automatic int unsigned clamp_limit(input int unsigned req,
                                                input int unsigned top);
        if (req == 0)
            return 1;
        else if (req > top)
            return top;
        else
            return req;
    endfunction

endpackage

// File: rtl/f2b_dbl_step.sv
// One doubling step: 2*rem compared against the denominator.
module f2b_dbl_step #(
    parameter int DEN  = 10000,
    parameter int IN_W = 14
) (
    input  logic [IN_W-1:0] rem_i,
    output logic            bit_o,
    output logic [IN_W-1:0] rem_o
);
    localparam logic [IN_W-1:0] DEN_W = IN_W'(DEN);

    logic            carry;
    logic [IN_W-1:0] dbl_lo;

    // The doubled value is {carry, dbl_lo}; the denominator fits in IN_W bits.
    assign carry  = rem_i[IN_W-1];
    assign dbl_lo = {rem_i[IN_W-2:0], 1'b0};

    always_comb begin
        bit_o = carry || (dbl_lo >= DEN_W);
        // Modular subtraction is exact because the true difference is below DEN.
        rem_o = bit_o ? (dbl_lo - DEN_W) : dbl_lo;
    end

endmodule

// File: rtl/f2b_seq.sv
// Controller: state machine, remainder and step counter.
module f2b_seq
    import frac2bin_pkg::*;
#(
    parameter int DEN      = 10000,
    parameter int IN_W     = 14,
    parameter int MAX_BITS = 24,
    parameter int PREC_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IN_W-1:0]   numer,
    input  logic [PREC_W-1:0] prec,
    input  logic [IN_W-1:0]   rem_nxt,
    output logic [IN_W-1:0]   rem_q,
    output logic [PREC_W-1:0] cnt_q,
    output logic              load,
    output logic              emit,
    output logic              finish,
    output logic              busy
);
    localparam logic [IN_W:0] DEN_V = (IN_W+1)'(DEN);

    f2b_state_e        state_q, state_d;
    logic [PREC_W-1:0] lim_q, lim_d;
    logic              last_step;

    assign lim_d     = PREC_W'(clamp_limit(32'(prec), MAX_BITS));
    assign load      = (state_q == ST_IDLE) && start && ({1'b0, numer} < DEN_V);
    assign emit      = (state_q == ST_RUN);
    assign finish    = (state_q == ST_WRAP);
    assign busy      = (state_q != ST_IDLE);
    assign last_step = (rem_nxt == '0) || ((cnt_q + 1'b1) == lim_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = (numer == '0) ? ST_WRAP : ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_WRAP;
            ST_WRAP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            rem_q <= numer;
            cnt_q <= '0;
            lim_q <= lim_d;
        end else if (emit) begin
            rem_q <= rem_nxt;
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/f2b_collect.sv
// Output registers: serial strobe, parallel result, end status.
module f2b_collect #(
    parameter int MAX_BITS = 24,
    parameter int PREC_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                emit,
    input  logic                bit_i,
    input  logic [PREC_W-1:0]   idx,
    input  logic                finish,
    input  logic                rem_zero,
    output logic                bit_valid,
    output logic                bit_out,
    output logic                done,
    output logic                exact,
    output logic [MAX_BITS-1:0] result,
    output logic [PREC_W-1:0]   nbits
);
    logic [MAX_BITS-1:0] hit;

    // Position decode: step g lands at result[MAX_BITS-1-g].
    for (genvar g = 0; g < MAX_BITS; g++) begin : g_pos
        assign hit[MAX_BITS-1-g] = (idx == PREC_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
            done      <= 1'b0;
            exact     <= 1'b0;
            result    <= '0;
            nbits     <= '0;
        end else begin
            bit_valid <= emit;
            bit_out   <= emit & bit_i;
            done      <= finish;
            if (load) begin
                result <= '0;
                exact  <= 1'b0;
                nbits  <= '0;
            end else if (emit) begin
                result <= result | (hit & {MAX_BITS{bit_i}});
            end
            if (finish) begin
                exact <= rem_zero;
                nbits <= idx;
            end
        end
    end

endmodule

// File: rtl/frac2bin_serial.sv
module frac2bin_serial #(
    parameter int DIGITS   = 4,
    parameter int MAX_BITS = 24,
    parameter int DEN      = 10 ** DIGITS,
    parameter int IN_W     = $clog2(DEN),
    parameter int PREC_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IN_W-1:0]     numer,
    input  logic [PREC_W-1:0]   prec,
    output logic                busy,
    output logic                bit_valid,
    output logic                bit_out,
    output logic                done,
    output logic                exact,
    output logic [MAX_BITS-1:0] result,
    output logic [PREC_W-1:0]   nbits
);
    logic [IN_W-1:0]   rem_q, rem_nxt;
    logic [PREC_W-1:0] cnt_q;
    logic              step_bit, load, emit, finish;

    f2b_dbl_step #(.DEN(DEN), .IN_W(IN_W)) u_step (
        .rem_i (rem_q),
        .bit_o (step_bit),
        .rem_o (rem_nxt)
    );

    f2b_seq #(.DEN(DEN), .IN_W(IN_W), .MAX_BITS(MAX_BITS), .PREC_W(PREC_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .numer   (numer),
        .prec    (prec),
        .rem_nxt (rem_nxt),
        .rem_q   (rem_q),
        .cnt_q   (cnt_q),
        .load    (load),
        .emit    (emit),
        .finish  (finish),
        .busy    (busy)
    );

    f2b_collect #(.MAX_BITS(MAX_BITS), .PREC_W(PREC_W)) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .emit      (emit),
        .bit_i     (step_bit),
        .idx       (cnt_q),
        .finish    (finish),
        .rem_zero  (rem_q == '0),
        .bit_valid (bit_valid),
        .bit_out   (bit_out),
        .done      (done),
        .exact     (exact),
        .result    (result),
        .nbits     (nbits)
    );

endmodule

// File: rtl/f2b_checker.sv
module f2b_checker #(
    parameter int DIGITS   = 4,
    parameter int MAX_BITS = 24,
    parameter int DEN      = 10 ** DIGITS,
    parameter int IN_W     = $clog2(DEN),
    parameter int PREC_W   = $clog2(MAX_BITS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [IN_W-1:0]     numer,
    input logic                busy,
    input logic                bit_valid,
    input logic                done,
    input logic                exact,
    input logic [MAX_BITS-1:0] result,
    input logic [PREC_W-1:0]   nbits
);
    localparam logic [IN_W:0] DEN_V = (IN_W+1)'(DEN);

    logic ok_num;
    assign ok_num = ({1'b0, numer} < DEN_V);

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ok_num) |=> busy);

    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !ok_num) |=> (!busy && !bit_valid));

    a_r3_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(busy));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bit_valid));

    a_r5_nbits_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((nbits >= 1 || exact) && nbits <= PREC_W'(MAX_BITS)));

    a_r8_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ok_num) |=> (result == '0));

    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind frac2bin_serial f2b_checker #(.DIGITS(DIGITS), .MAX_BITS(MAX_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .numer     (numer),
    .busy      (busy),
    .bit_valid (bit_valid),
    .done      (done),
    .exact     (exact),
    .result    (result),
    .nbits     (nbits)
);

// File: tb/frac2bin_serial_bench.sv
module frac2bin_serial_bench;
    localparam int DIGITS   = 4;
    localparam int MAX_BITS = 24;
    localparam int DEN      = 10000;
    localparam int IN_W     = 14;
    localparam int PREC_W   = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [IN_W-1:0]     numer = '0;
    logic [PREC_W-1:0]   prec = '0;
    logic                busy, bit_valid, bit_out, done, exact;
    logic [MAX_BITS-1:0] result;
    logic [PREC_W-1:0]   nbits;

    int n_tests = 0;
    int n_fail  = 0;
    logic [MAX_BITS-1:0] last_result = '0;

    always #5 clk = ~clk;

    frac2bin_serial #(.DIGITS(DIGITS), .MAX_BITS(MAX_BITS)) u_frac2bin_serial (
        .clk(clk), .rst_n(rst_n), .start(start), .numer(numer), .prec(prec),
        .busy(busy), .bit_valid(bit_valid), .bit_out(bit_out), .done(done),
        .exact(exact), .result(result), .nbits(nbits)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lim_of(input int p);
        if (p == 0) return 1;
        if (p > MAX_BITS) return MAX_BITS;
        return p;
    endfunction

    // Runs one accepted conversion and checks every result at its due cycle.
    task automatic run_conv(input int nm, input int pr, input bit poke);
        logic [MAX_BITS-1:0] er = '0;
        int en = 0;
        int r = nm;
        bit ex;
        if (nm != 0) begin
            for (int i = 0; i < lim_of(pr); i++) begin
                r = r * 2;
                if (r >= DEN) begin
                    er[MAX_BITS-1-i] = 1'b1;
                    r = r - DEN;
                end
                en++;
                if (r == 0) break;
            end
        end
        ex = (r == 0);
        @(negedge clk);
        numer = IN_W'(nm);
        prec  = PREC_W'(pr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke && en > 0) begin
            start = 1'b1;            // R10: sampled while busy
            numer = IN_W'(7);
            prec  = PREC_W'(3);
        end
        for (int i = 0; i < en; i++) begin
            @(negedge clk);
            start = 1'b0;
            check(bit_valid == 1'b1, "R3", "bit_valid", bit_valid, 1);
            check(bit_out == er[MAX_BITS-1-i], poke ? "R10" : "R3", "bit_out",
                  bit_out, er[MAX_BITS-1-i]);
        end
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R7", "done/busy", {done, busy}, 2);
        check(result == er, nm == 0 ? "R6" : "R8", "result", result, er);
        check(nbits == PREC_W'(en), ex && nm != 0 ? "R4" : "R5", "nbits", nbits, en);
        check(exact == ex, "R9", "exact", exact, ex);
        @(negedge clk);
        check(done == 1'b0, "R7", "done one cycle", done, 0);
        check(nbits == PREC_W'(en), "R9", "nbits held", nbits, en);
        last_result = er;
    endtask

    task automatic reject(input int nm);
        @(negedge clk);
        numer = IN_W'(nm);
        prec  = PREC_W'(8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0 && bit_valid == 1'b0, "R2", "reject busy/valid",
              {busy, bit_valid}, 0);
        @(negedge clk);
        check(done == 1'b0, "R2", "reject done", done, 0);
        check(result == last_result, "R2", "reject result", result, last_result);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !bit_valid && !bit_out && !done && !exact, "R1", "flags",
              {busy, bit_valid, bit_out, done, exact}, 0);
        check(result == '0 && nbits == '0, "R1", "result/nbits", result, 0);

        run_conv(5625, 24, 1'b0);   // R4: 1001, exact
        run_conv(5625, 2, 1'b0);    // R5: limit reached first
        run_conv(3333, 0, 1'b0);    // R5: prec 0 gives one bit
        run_conv(1, 31, 1'b0);      // R5: clamp to 24
        run_conv(0, 12, 1'b0);      // R6: zero numerator
        run_conv(5000, 24, 1'b0);   // R4: single bit
        run_conv(9999, 24, 1'b0);
        run_conv(3333, 10, 1'b1);   // R10: start while busy
        reject(10000);              // R2
        reject(16383);              // R2

        for (int k = 0; k < 60; k++) begin
            int nm = int'($urandom % DEN);
            int pr = int'($urandom % 32);
            if (k % 8 == 0) nm = 625 * int'($urandom % 16);
            run_conv(nm, pr, (k % 5) == 0);
            if (k % 10 == 0) reject(DEN + int'($urandom % 6000));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule